// File: doc/BRIEF.md
# Sigma-Delta Fractional-N Divider Controller

This block steers the feedback divider of a fractional-N synthesizer so that, over many reference periods, the divider divides by INT + FRAC/MOD, where MOD is any value from 1 to 4095. It does not change the divide value every reference cycle on its own. A third-order noise-shaping modulator, built as three cascaded accumulators that wrap at MOD, produces a small signed offset once per division cycle. That offset is added to INT to give the instantaneous divide value N[k].

Each N[k] is split into a B count and an A count for a dual-modulus prescaler that divides by P or P+1, with P equal to 4 or 8. Over one division cycle the block receives B prescaler output strobes. During the first A of those prescaler periods it raises the modulus-control output to request P+1, so the cycle spans P·B + A input cycles. At the end of each cycle it emits a one-cycle divided pulse and loads the next N[k]. The block runs on the divider clock and takes a strobe for each completed prescaler period. A synchronous counter reset holds it idle and clears the modulator.

Top module: `frac_n_div_ctl`

## Requirements
- R1: Starting from a counter reset with FRAC < MOD, the sum of the first K divide values N[0..K-1] equals K·INT + floor(K·FRAC/MOD) plus an error e with −1 ≤ e ≤ 2 for every K. For K a multiple of MOD, this makes the long-run average INT + FRAC/MOD.
- R2: Every divide value N[k] lies in INT−3 .. INT+4.
- R3: With FRAC = 0, every divide value equals INT.
- R4: A division cycle spans P·B + A divider-clock cycles, where P = 4 when ps_sel = 0 and P = 8 when ps_sel = 1, B = N[k] div P and A = N[k] mod P. mod_ctl is high during exactly the first A prescaler periods of the cycle. This holds for INT ≥ P·P.
- R5: mod_ctl changes only in the cycle after a pre_tick or after a cycle with cnt_rst high. The value it has then selects the prescaler modulus of the period that follows (1 = P+1).
- R6: While cnt_rst is high, div_pulse and mod_ctl stay low and all three accumulators are cleared.
- R7: div_pulse is high for one cycle, in the cycle that follows the pre_tick ending a division cycle. The first pre_tick after a reset ends a priming cycle and loads N[0].
- R8: A new N[k] is taken from INT, FRAC, MOD and ps_sel only at the end of a division cycle. A change during a cycle leaves the length of that cycle unchanged.
- R9: While rst_n is low, mod_ctl and div_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_rst | input | 1 | Synchronous hold of counters and modulator |
| pre_tick | input | 1 | One-cycle strobe at the end of each prescaler period |
| ps_sel | input | 1 | Prescaler ratio: 0 selects 4/5, 1 selects 8/9 |
| int_val | input | 12 | Integer part INT of the division ratio |
| frac_val | input | 12 | Fractional numerator FRAC (must be below MOD) |
| mod_val | input | 12 | Fractional modulus MOD |
| mod_ctl | output | 1 | Prescaler modulus request, 1 = divide by P+1 |
| div_pulse | output | 1 | One-cycle pulse per completed division cycle |

## Verification
The hardest behaviour to reach from the ports is the bounded residual of R1. That residual depends on when the second and third accumulators carry, which only shows up after long runs with FRAC/MOD ratios that are coprime or close to 1. The bench therefore sweeps every FRAC for several small moduli over 8·MOD division cycles. It also runs near-full-scale moduli, and it uses a behavioural prescaler that obeys mod_ctl, so each cycle length is measured in clock cycles. A run at P = 8 with INT = 59 drives N down to 56 and up to 63, where the A count reaches the B count. A change of INT right after a pulse exposes any load in mid-cycle.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int MASH_ORDER = 3;
  localparam int OFF_W      = 4;
  localparam int PS_LO_LOG2 = 2;
  localparam int PS_HI_LOG2 = 3;
  typedef enum logic {PS_LO = 1'b0, PS_HI = 1'b1} ps_mode_e;
endpackage

// File: rtl/fnd_rst_sync.sv
module fnd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/fnd_acc_stage.sv
// One modulo-MOD accumulator with carry out.
module fnd_acc_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] addend,
  input  logic [W-1:0] modulus,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] acc_nx,
  output logic         carry
);
  logic [W:0]   sum;
  logic [W:0]   wrapped;
  logic [W-1:0] acc_d;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, addend};
    carry   = (sum >= {1'b0, modulus});
    wrapped = sum - {1'b0, modulus};
    acc_nx  = carry ? wrapped[W-1:0] : sum[W-1:0];
  end

  always_comb begin
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (step) begin
      acc_d = acc_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/fnd_sdm.sv
// Three-stage cascaded modulator with carry recombination.
module fnd_sdm
  import fnd_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           step,
  input  logic [W-1:0]                   frac_i,
  input  logic [W-1:0]                   mod_i,
  output logic signed [OFF_W-1:0]        off_o,
  output logic [MASH_ORDER-1:0][W-1:0]   acc_o
);
  logic [MASH_ORDER-1:0][W-1:0] add_v;
  logic [MASH_ORDER-1:0][W-1:0] nx_v;
  logic [MASH_ORDER-1:0]        cy;
  logic c2_dq, c3_dq, c3_ddq;
  logic c2_dd, c3_dd, c3_ddd;
  int   off_sum;

  for (genvar i = 0; i < MASH_ORDER; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign add_v[i] = frac_i;
    end else begin : g_next
      assign add_v[i] = nx_v[i-1];
    end
    fnd_acc_stage #(.W(W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .step    (step),
      .addend  (add_v[i]),
      .modulus (mod_i),
      .acc_q   (acc_o[i]),
      .acc_nx  (nx_v[i]),
      .carry   (cy[i])
    );
  end

  always_comb begin
    off_sum = int'(cy[0]) + int'(cy[1]) - int'(c2_dq)
            + int'(cy[2]) - 2 * int'(c3_dq) + int'(c3_ddq);
    off_o   = off_sum[OFF_W-1:0];
  end

  always_comb begin
    c2_dd  = c2_dq;
    c3_dd  = c3_dq;
    c3_ddd = c3_ddq;
    if (clr) begin
      c2_dd  = 1'b0;
      c3_dd  = 1'b0;
      c3_ddd = 1'b0;
    end else if (step) begin
      c2_dd  = cy[1];
      c3_dd  = cy[2];
      c3_ddd = c3_dq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_dq  <= 1'b0;
      c3_dq  <= 1'b0;
      c3_ddq <= 1'b0;
    end else begin
      c2_dq  <= c2_dd;
      c3_dq  <= c3_dd;
      c3_ddq <= c3_ddd;
    end
  end
endmodule

// File: rtl/fnd_dual_mod.sv
// B/A remainder counters driving the prescaler modulus request.
module fnd_dual_mod #(
  parameter int B_W = 9,
  parameter int A_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           tick,
  input  logic [B_W-1:0] load_b,
  input  logic [A_W-1:0] load_a,
  output logic           cyc_end,
  output logic           mod_ctl,
  output logic           div_pulse
);
  localparam logic [B_W-1:0] B_ONE = B_W'(1);
  localparam logic [A_W-1:0] A_ONE = A_W'(1);

  logic [B_W-1:0] b_q, b_d;
  logic [A_W-1:0] a_q, a_d;
  logic           p_d;

  always_comb begin
    cyc_end = tick && (b_q <= B_ONE);
    b_d     = b_q;
    a_d     = a_q;
    p_d     = 1'b0;
    if (clr) begin
      b_d = B_ONE;
      a_d = '0;
    end else if (tick) begin
      if (cyc_end) begin
        b_d = load_b;
        a_d = load_a;
        p_d = 1'b1;
      end else begin
        b_d = b_q - B_ONE;
        if (a_q != '0) begin
          a_d = a_q - A_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q       <= B_ONE;
      a_q       <= '0;
      div_pulse <= 1'b0;
    end else begin
      b_q       <= b_d;
      a_q       <= a_d;
      div_pulse <= p_d;
    end
  end

  assign mod_ctl = (a_q != '0);
endmodule

// File: rtl/frac_n_div_ctl.sv
module frac_n_div_ctl
  import fnd_pkg::*;
#(
  parameter int FRAC_W = 12,
  parameter int B_W    = 9,
  parameter int A_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnt_rst,
  input  logic                 pre_tick,
  input  logic                 ps_sel,
  input  logic [B_W+A_W-1:0]   int_val,
  input  logic [FRAC_W-1:0]    frac_val,
  input  logic [FRAC_W-1:0]    mod_val,
  output logic                 mod_ctl,
  output logic                 div_pulse
);
  localparam int N_W = B_W + A_W;

  logic                              sync_rst_n;
  logic                              cyc_end;
  logic signed [OFF_W-1:0]           off;
  logic [MASH_ORDER-1:0][FRAC_W-1:0] acc;
  logic [N_W-1:0]                    off_ext;
  logic [N_W-1:0]                    n_now;
  logic [N_W-1:0]                    lo_mask;
  logic [N_W-1:0]                    n_hi;
  logic [B_W-1:0]                    load_b;
  logic [A_W-1:0]                    load_a;
  ps_mode_e                          ps_mode;

  fnd_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (sync_rst_n)
  );

  fnd_sdm #(.W(FRAC_W)) u_sdm (
    .clk    (clk),
    .rst_n  (sync_rst_n),
    .clr    (cnt_rst),
    .step   (cyc_end),
    .frac_i (frac_val),
    .mod_i  (mod_val),
    .off_o  (off),
    .acc_o  (acc)
  );

  always_comb begin
    ps_mode = ps_mode_e'(ps_sel);
    off_ext = {{(N_W-OFF_W){off[OFF_W-1]}}, off};
    n_now   = int_val + off_ext;
    if (ps_mode == PS_HI) begin
      n_hi    = n_now >> PS_HI_LOG2;
      lo_mask = N_W'((1 << PS_HI_LOG2) - 1);
    end else begin
      n_hi    = n_now >> PS_LO_LOG2;
      lo_mask = N_W'((1 << PS_LO_LOG2) - 1);
    end
    load_b = n_hi[B_W-1:0];
    load_a = A_W'(n_now & lo_mask);
  end

  fnd_dual_mod #(.B_W(B_W), .A_W(A_W)) u_cnt (
    .clk       (clk),
    .rst_n     (sync_rst_n),
    .clr       (cnt_rst),
    .tick      (pre_tick),
    .load_b    (load_b),
    .load_a    (load_a),
    .cyc_end   (cyc_end),
    .mod_ctl   (mod_ctl),
    .div_pulse (div_pulse)
  );
endmodule

// File: rtl/fnd_chk.sv
module fnd_chk
  import fnd_pkg::*;
#(
  parameter int FRAC_W = 12
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              cnt_rst,
  input logic                              pre_tick,
  input logic                              mod_ctl,
  input logic                              div_pulse,
  input logic [FRAC_W-1:0]                 frac_val,
  input logic [FRAC_W-1:0]                 mod_val,
  input logic signed [OFF_W-1:0]           off,
  input logic [MASH_ORDER-1:0][FRAC_W-1:0] acc
);
  a_r6_cnt_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> (!div_pulse && !mod_ctl));

  a_r7_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(pre_tick));

  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  a_r5_modctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pre_tick) && !$past(cnt_rst)) |-> $stable(mod_ctl));

  a_r2_off_range: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_rst |-> (off >= -4'sd3 && off <= 4'sd4));

  for (genvar i = 0; i < MASH_ORDER; i++) begin : g_acc
    a_r1_acc_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_rst && !$past(cnt_rst) && frac_val < mod_val) |-> (acc[i] < mod_val));
  end
endmodule

bind frac_n_div_ctl fnd_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (sync_rst_n),
  .cnt_rst   (cnt_rst),
  .pre_tick  (pre_tick),
  .mod_ctl   (mod_ctl),
  .div_pulse (div_pulse),
  .frac_val  (frac_val),
  .mod_val   (mod_val),
  .off       (off),
  .acc       (acc)
);

// File: tb/frac_n_div_ctl_test.sv
module frac_n_div_ctl_test;
  localparam int FW = 12;
  localparam int NW = 12;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cnt_rst, pre_tick, ps_sel;
  logic [NW-1:0] int_val;
  logic [FW-1:0] frac_val, mod_val;
  logic mod_ctl, div_pulse;

  frac_n_div_ctl uut (
    .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .pre_tick(pre_tick),
    .ps_sel(ps_sel), .int_val(int_val), .frac_val(frac_val),
    .mod_val(mod_val), .mod_ctl(mod_ctl), .div_pulse(div_pulse)
  );

  int total = 0, bad = 0, wd = 0;
  int cyc = 0, ps_rem = 4, ps_len = 4;
  logic cr_seen = 1'b1, mc_prev = 1'b0;
  logic armed = 1'b0, seen_first = 1'b0;
  int last_pc = 0, nint = 0, sum = 0, min_n = 0, max_n = 0, last_iv = 0;
  int tk_in = 0, hi_in = 0, split_bad = 0, r5_bad = 0, r7_bad = 0;
  int pulse_cnt = 0, mc_hi_cnt = 0;

  function automatic int pval();
    return ps_sel ? 8 : 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural prescaler and port monitor, all at the falling edge
  always @(negedge clk) begin
    int iv;
    cyc++;
    if (rst_n) begin
      if (mod_ctl !== mc_prev && !pre_tick && !cr_seen) r5_bad++;
      if (div_pulse && !pre_tick) r7_bad++;
    end
    if (div_pulse) pulse_cnt++;
    if (mod_ctl) mc_hi_cnt++;
    if (pre_tick) begin
      tk_in++;
      if (ps_len == pval() + 1) hi_in++;
    end
    if (div_pulse && armed) begin
      if (seen_first) begin
        iv = cyc - last_pc;
        nint++;
        sum += iv;
        last_iv = iv;
        if (iv < min_n) min_n = iv;
        if (iv > max_n) max_n = iv;
        if (tk_in != iv / pval() || hi_in != iv % pval()) split_bad++;
      end
      seen_first = 1'b1;
      last_pc = cyc;
      tk_in = 0;
      hi_in = 0;
    end
    if (pre_tick) begin
      ps_len = pval() + (mod_ctl ? 1 : 0);
      ps_rem = ps_len;
    end
    pre_tick = (ps_rem == 1);
    ps_rem--;
    cr_seen = cnt_rst;
    mc_prev = mod_ctl;
  end

  always @(posedge clk) begin
    wd++;
    if (wd == WD_LIMIT) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic start_case(input bit ps, input int iv, input int fr, input int md);
    @(posedge clk); #2;
    armed    = 1'b0;
    cnt_rst  = 1'b1;
    ps_sel   = ps;
    int_val  = NW'(iv);
    frac_val = FW'(fr);
    mod_val  = FW'(md);
    repeat (3) @(posedge clk);
    #2;
    seen_first = 1'b0;
    nint = 0; sum = 0; min_n = 1000000; max_n = 0; split_bad = 0;
    armed   = 1'b1;
    cnt_rst = 1'b0;
  endtask

  task automatic wait_n(input int n);
    while (nint < n) @(posedge clk);
  endtask

  task automatic run_case(input bit ps, input int iv, input int fr, input int md, input int k);
    int ideal, e;
    start_case(ps, iv, fr, md);
    wait_n(k);
    armed = 1'b0;
    ideal = k * iv + (k * fr) / md;
    e = sum - ideal;
    chk(e >= -1 && e <= 2, "R1 sum of divide values", sum, ideal);
    chk(min_n >= iv - 3, "R2 lowest divide value", min_n, iv - 3);
    chk(max_n <= iv + 4, "R2 highest divide value", max_n, iv + 4);
    if (fr == 0) begin
      chk(min_n == iv && max_n == iv, "R3 constant divide value", max_n, iv);
    end
    chk(split_bad == 0, "R4 B/A split of cycles", split_bad, 0);
  endtask

  initial begin
    int p0, m0;
    rst_n = 1'b0; cnt_rst = 1'b0; pre_tick = 1'b0; ps_sel = 1'b0;
    int_val = NW'(27); frac_val = '0; mod_val = FW'(7);
    repeat (4) @(posedge clk);
    #2;
    chk(mod_ctl == 1'b0, "R9 mod_ctl in reset", int'(mod_ctl), 0);
    chk(div_pulse == 1'b0, "R9 div_pulse in reset", int'(div_pulse), 0);
    rst_n = 1'b1;
    repeat (200) @(posedge clk);
    chk(pulse_cnt > 0 && mc_hi_cnt > 0, "R7 activity before hold", pulse_cnt, 1);

    // R6: hold counter reset with the prescaler running
    #2; cnt_rst = 1'b1;
    repeat (2) @(posedge clk);
    p0 = pulse_cnt; m0 = mc_hi_cnt;
    repeat (100) @(posedge clk);
    chk(pulse_cnt == p0, "R6 no pulse during hold", pulse_cnt - p0, 0);
    chk(mc_hi_cnt == m0, "R6 mod_ctl low during hold", mc_hi_cnt - m0, 0);

    // near-exhaustive FRAC sweeps for small moduli
    for (int f = 0; f < 7; f++) run_case(1'b0, 24, f, 7, 56);
    for (int f = 0; f < 10; f++) run_case(1'b0, 22, f, 10, 80);
    for (int f = 0; f < 5; f++) run_case(1'b1, 70, f, 5, 40);
    run_case(1'b0, 20, 1, 13, 104);
    run_case(1'b0, 20, 6, 13, 104);
    run_case(1'b0, 20, 12, 13, 104);
    run_case(1'b0, 17, 0, 1, 10);
    // boundary: P=8, N spans 56..63, A reaches B
    run_case(1'b1, 59, 3, 7, 56);
    run_case(1'b1, 59, 6, 7, 56);
    // large moduli
    run_case(1'b1, 100, 2047, 4095, 300);
    run_case(1'b0, 40, 4094, 4095, 150);

    // R8: INT changed just after a pulse applies from the following cycle
    start_case(1'b0, 24, 0, 7);
    wait_n(2);
    @(posedge clk); #2;
    int_val = NW'(30);
    wait_n(3);
    chk(last_iv == 24, "R8 cycle in progress keeps length", last_iv, 24);
    wait_n(4);
    chk(last_iv == 30, "R8 new INT in next cycle", last_iv, 30);
    armed = 1'b0;

    chk(r5_bad == 0, "R5 mod_ctl moves only after pre_tick", r5_bad, 0);
    chk(r7_bad == 0, "R7 pulse follows ending pre_tick", r7_bad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule